// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital control unit of a 10-bit successive-approximation converter. A host starts a conversion by setting a start/busy flag and chooses how long an automatic acquisition lasts before the capacitor is cut off from the input. The block then runs the optional acquisition and resolves the result one bit per conversion-clock period, from the most significant bit down. It stores the result, drops the busy flag and raises a sticky interrupt flag. It then discharges the capacitor array for a fixed two-period wait before the input is sampled again.

Every step moves only on a single-cycle conversion-clock enable (`tad_tick_i`). The comparator, the DAC and the capacitor array are outside the block. The block drives a trial code to the DAC, reads back one comparator bit, and controls the sample switch and the discharge line. If the host clears the busy flag while a conversion is in progress, the conversion is abandoned and the stored result is left as it was.

Top module: `sar_seq`

## Requirements
- R1: After reset `go_o`=0, `irq_o`=0, `res_o`=0, `sample_o`=1, `discharge_o`=0 and `dac_code_o`=0.
- R2: With `acq_sel_i`=3'b000, conversion starts on the first tick after `go_o` becomes 1. `go_o` falls on the 12th tick counted from that first tick.
- R3: `acq_sel_i` picks the acquisition length in ticks as follows: 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20. A conversion with length n clears `go_o` on tick 12+n.
- R4: `sample_o` is 1 while idle, acquiring or waiting. It is 0 from conversion start until the result is loaded.
- R5: Bits are resolved from bit 9 down to bit 0. During each step `dac_code_o` holds the bits already kept, with the bit under test set. A bit is kept when `cmp_i`=1, meaning input ≥ DAC, and cleared otherwise.
- R6: On the tick after bit 0 is resolved, `res_o` takes the resolved code, `go_o` clears and `irq_o` sets, all on the same clock.
- R7: Pulsing `go_clr_i` during acquisition or conversion aborts the conversion. `go_o` clears on the next clock, and `res_o` and `irq_o` are left unchanged.
- R8: After a completion or an abort, `discharge_o` stays 1 for exactly 2 ticks. No acquisition or conversion starts during that time, and a start requested then is held until it ends.
- R9: `irq_o` stays set until `irq_clr_i` is pulsed. If a set and a clear fall on the same clock, the set wins.
- R10: A `res_wr_i` write loads `res_wdata_i` into `res_o` while idle or waiting. The write is ignored during acquisition, conversion or result load.
- R11: With `tad_tick_i` held low, the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tad_tick_i | input | 1 | Single-cycle conversion-clock enable |
| go_set_i | input | 1 | Host pulse: request a conversion |
| go_clr_i | input | 1 | Host pulse: clear the busy flag / abort |
| acq_sel_i | input | 3 | Acquisition-length select |
| res_wr_i | input | 1 | Host write strobe for the result register |
| res_wdata_i | input | 10 | Host write data for the result register |
| irq_clr_i | input | 1 | Host pulse: clear the interrupt flag |
| cmp_i | input | 1 | Comparator: 1 when input ≥ DAC output |
| go_o | output | 1 | Start/busy flag |
| res_o | output | 10 | Result register |
| irq_o | output | 1 | Sticky conversion-done flag |
| dac_code_o | output | 10 | Trial code to the DAC (0 outside conversion) |
| sample_o | output | 1 | Sample switch closed (holding capacitor on input) |
| discharge_o | output | 1 | Capacitor-array discharge / wait interval |

## Verification
The assertions assume that `tad_tick_i` is a single-cycle pulse and that the host strobes are one-clock pulses. They also assume that `cmp_i` is a function of the present `dac_code_o` alone, as an ideal comparator would give. The stimulus raises the tick for one clock in every three and holds each host strobe for exactly one clock. It derives `cmp_i` combinationally from a fixed analog code compared with `dac_code_o`, so every completed conversion must return that code.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_LOAD,
    ST_WAIT
  } seq_state_e;

  // acquisition length in TAD periods
  function automatic logic [4:0] acq_tad(input logic [2:0] sel);
    case (sel)
      3'd0:    acq_tad = 5'd0;
      3'd1:    acq_tad = 5'd2;
      3'd2:    acq_tad = 5'd4;
      3'd3:    acq_tad = 5'd6;
      3'd4:    acq_tad = 5'd8;
      3'd5:    acq_tad = 5'd12;
      3'd6:    acq_tad = 5'd16;
      default: acq_tad = 5'd20;
    endcase
  endfunction

endpackage

// File: rtl/sar_tad_timer.sv
module sar_tad_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  assert_count_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [N-1:0] trial_o,
  output logic [N-1:0] code_o,
  output logic         last_o
);

  localparam int IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N - 1);
  localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0]     code_q;
  logic [IDX_W-1:0] idx_q;
  logic [N-1:0]     cur_bit;

  assign cur_bit = {{(N-1){1'b0}}, 1'b1} << idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      code_q <= '0;
      idx_q  <= TOP_IDX;
    end else if (step_i) begin
      code_q <= cmp_i ? (code_q | cur_bit) : (code_q & ~cur_bit);
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end

  assign trial_o = code_q | cur_bit;
  assign code_o  = code_q;
  assign last_o  = (idx_q == '0);

  assert_msb_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> trial_o == TOP_BIT);

  assert_keep_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i) |=> code_o[$past(idx_q)] == $past(cmp_i));

endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] load_data_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic         irq_set_i,
  input  logic         irq_clr_i,
  output logic [N-1:0] res_o,
  output logic         irq_o
);

  logic [N-1:0] res_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_q <= '0;
    else if (load_i)  res_q <= load_data_i;
    else if (wr_i)    res_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         irq_q <= 1'b0;
    else if (irq_set_i)  irq_q <= 1'b1;
    else if (irq_clr_i)  irq_q <= 1'b0;
  end

  assign res_o = res_q;
  assign irq_o = irq_q;

  assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);

  assert_irq_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> irq_q);

  assert_res_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !wr_i) |=> $stable(res_q));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int CNT_W    = 5,
  parameter int WAIT_TAD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tad_tick_i,
  input  logic             go_set_i,
  input  logic             go_clr_i,
  input  logic [2:0]       acq_sel_i,
  input  logic             res_wr_i,
  input  logic [RES_W-1:0] res_wdata_i,
  input  logic             irq_clr_i,
  input  logic             cmp_i,
  output logic             go_o,
  output logic [RES_W-1:0] res_o,
  output logic             irq_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             sample_o,
  output logic             discharge_o
);

  localparam logic [CNT_W-1:0] WAIT_VAL = CNT_W'(WAIT_TAD);

  seq_state_e       state_q, state_d;
  logic             go_q;
  logic             busy, abort;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val, acq_n;
  logic             sar_start, sar_step, sar_last;
  logic             load_ev;
  logic [RES_W-1:0] trial, code;

  assign acq_n = CNT_W'(acq_tad(acq_sel_i));
  assign busy  = (state_q == ST_ACQ) || (state_q == ST_CONV) || (state_q == ST_LOAD);
  assign abort = go_clr_i && busy;

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    sar_start = 1'b0;
    sar_step  = 1'b0;
    load_ev   = 1'b0;
    case (state_q)
      ST_IDLE: if (go_q && tad_tick_i) begin
        if (acq_n == '0) begin
          state_d   = ST_CONV;
          sar_start = 1'b1;
        end else begin
          state_d  = ST_ACQ;
          tmr_load = 1'b1;
          tmr_val  = acq_n;
        end
      end
      ST_ACQ: if (tad_tick_i && tmr_last) begin
        state_d   = ST_CONV;
        sar_start = 1'b1;
      end
      ST_CONV: if (tad_tick_i) begin
        sar_step = 1'b1;
        if (sar_last) state_d = ST_LOAD;
      end
      ST_LOAD: if (tad_tick_i) begin
        load_ev  = 1'b1;
        state_d  = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = WAIT_VAL;
      end
      ST_WAIT: if (tad_tick_i && tmr_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    // abort overrides any step
    if (abort) begin
      state_d   = ST_WAIT;
      tmr_load  = 1'b1;
      tmr_val   = WAIT_VAL;
      sar_start = 1'b0;
      sar_step  = 1'b0;
      load_ev   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        go_q <= 1'b0;
    else if (go_clr_i)  go_q <= 1'b0;
    else if (load_ev)   go_q <= 1'b0;
    else if (go_set_i)  go_q <= 1'b1;
  end

  sar_tad_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (tad_tick_i),
    .last_o     (tmr_last)
  );

  sar_approx #(.N(RES_W)) u_approx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sar_start),
    .step_i  (sar_step),
    .cmp_i   (cmp_i),
    .trial_o (trial),
    .code_o  (code),
    .last_o  (sar_last)
  );

  sar_result #(.N(RES_W)) u_result (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_ev),
    .load_data_i (code),
    .wr_i        (res_wr_i && !busy),
    .wdata_i     (res_wdata_i),
    .irq_set_i   (load_ev),
    .irq_clr_i   (irq_clr_i),
    .res_o       (res_o),
    .irq_o       (irq_o)
  );

  assign go_o        = go_q;
  assign dac_code_o  = (state_q == ST_CONV) ? trial : '0;
  assign sample_o    = !((state_q == ST_CONV) || (state_q == ST_LOAD));
  assign discharge_o = (state_q == ST_WAIT);

  assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && tad_tick_i && !go_clr_i)
      |=> (irq_o && !go_o && sample_o && res_o == $past(code)));

  assert_abort_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!go_o && res_o == $past(res_o) && discharge_o));

  assert_wait_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> (state_q == ST_WAIT || state_q == ST_IDLE));

  assert_open_in_conv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_o) |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_ACQ));

  assert_no_tick_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tad_tick_i && !go_clr_i) |=> state_q == $past(state_q));

endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tick_en = 1'b1;
  int         div = 0;
  logic       go_set = 1'b0, go_clr = 1'b0, res_wr = 1'b0, irq_clr = 1'b0;
  logic [2:0] acq_sel = 3'd0;
  logic [9:0] res_wdata = '0;
  logic [9:0] vin = '0;
  logic       cmp;
  logic       go, irq, sample, disch;
  logic [9:0] res, dac;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  // tick: one clock in three, changes just after the rising edge
  always @(posedge clk) begin
    #1;
    if (div == 2) begin
      div = 0;
      tick = tick_en;
    end else begin
      div = div + 1;
      tick = 1'b0;
    end
  end

  assign cmp = (vin >= dac);

  sar_seq u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tad_tick_i  (tick),
    .go_set_i    (go_set),
    .go_clr_i    (go_clr),
    .acq_sel_i   (acq_sel),
    .res_wr_i    (res_wr),
    .res_wdata_i (res_wdata),
    .irq_clr_i   (irq_clr),
    .cmp_i       (cmp),
    .go_o        (go),
    .res_o       (res),
    .irq_o       (irq),
    .dac_code_o  (dac),
    .sample_o    (sample),
    .discharge_o (disch)
  );

  localparam logic [12:0] VEC [8] = '{
    {3'd0, 10'h2AA}, {3'd1, 10'h3FF}, {3'd2, 10'h000}, {3'd3, 10'h155},
    {3'd4, 10'h001}, {3'd5, 10'h200}, {3'd6, 10'h1FF}, {3'd7, 10'h37C}
  };

  function automatic int exp_acq(input logic [2:0] s);
    case (s)
      3'd0: return 0;   3'd1: return 2;   3'd2: return 4;   3'd3: return 6;
      3'd4: return 8;   3'd5: return 12;  3'd6: return 16;  default: return 20;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_go;
    @(negedge clk) go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
  endtask

  task automatic pulse_irq_clr;
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  // count ticks consumed until go_o falls
  task automatic run_conv(output int ticks);
    ticks = 0;
    for (int g = 0; g < 2000 && go; g++) begin
      if (tick) ticks++;
      @(negedge clk);
    end
  endtask

  // count ticks consumed while discharge_o is high
  task automatic drain(output int ticks);
    ticks = 0;
    for (int g = 0; g < 200 && disch; g++) begin
      if (tick) ticks++;
      @(negedge clk);
    end
  endtask

  task automatic consume_tick;
    for (int g = 0; g < 10 && !tick; g++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t;
    int bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 go", go, 0);
    check("R1 irq", irq, 0);
    check("R1 res", res, 0);
    check("R1 sample/disch", {sample, disch}, 2'b10);
    check("R1 dac", dac, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk over all acquisition codes
    for (int i = 0; i < 8; i++) begin
      acq_sel = VEC[i][12:10];
      vin     = VEC[i][9:0];
      pulse_go();
      run_conv(t);
      check(acq_sel == 3'd0 ? "R2 ticks" : "R3 ticks", t, 12 + exp_acq(acq_sel));
      check("R5 result", res, vin);
      check("R6 irq/go", {irq, go}, 2'b10);
      check("R4 sample after load", sample, 1);
      drain(t);
      check("R8 wait ticks", t, 2);
      pulse_irq_clr();
      check("R9 irq cleared", irq, 0);
    end

    // R5 trial sequence, R4 switch
    acq_sel = 3'd0;
    vin = 10'h2AA;
    pulse_go();
    for (int g = 0; g < 50 && sample; g++) @(negedge clk);
    check("R4 open in conv", sample, 0);
    check("R5 first trial", dac, 10'h200);
    consume_tick();
    check("R5 second trial", dac, 10'h300);
    consume_tick();
    check("R5 third trial", dac, 10'h280);
    run_conv(t);
    check("R5 directed result", res, 10'h2AA);
    drain(t);
    pulse_irq_clr();

    // R10 idle write, busy write ignored, R7 abort
    @(negedge clk) begin res_wr = 1'b1; res_wdata = 10'h155; end
    @(negedge clk) res_wr = 1'b0;
    check("R10 idle write", res, 10'h155);
    vin = 10'h3FF;
    pulse_go();
    repeat (4) consume_tick();
    @(negedge clk) begin res_wr = 1'b1; res_wdata = 10'h0F0; end
    @(negedge clk) res_wr = 1'b0;
    check("R10 busy write ignored", res, 10'h155);
    @(negedge clk) go_clr = 1'b1;
    @(negedge clk) go_clr = 1'b0;
    check("R7 abort go", go, 0);
    check("R7 abort res kept", res, 10'h155);
    check("R7 abort no irq", irq, 0);
    check("R8 abort discharge", {disch, sample}, 2'b11);
    drain(t);
    check("R8 abort wait ticks", t, 2);

    // R8 start requested during wait is held
    vin = 10'h123;
    pulse_go();
    run_conv(t);
    pulse_go();
    bad = 0;
    for (int g = 0; g < 50 && disch; g++) begin
      if (!sample || dac != 0 || !go) bad++;
      @(negedge clk);
    end
    check("R8 no start in wait", bad, 0);
    run_conv(t);
    check("R8 held start result", res, 10'h123);
    drain(t);

    // R11 no tick, no progress
    pulse_irq_clr();
    tick_en = 1'b0;
    repeat (4) @(negedge clk);
    acq_sel = 3'd2;
    vin = 10'h0C3;
    pulse_go();
    repeat (20) @(negedge clk);
    check("R11 held", {go, sample, disch}, 3'b110);
    check("R11 dac", dac, 0);
    tick_en = 1'b1;
    run_conv(t);
    check("R11 resumed result", res, 10'h0C3);

    // R9 stickiness
    repeat (12) @(negedge clk);
    check("R9 sticky", irq, 1);
    pulse_irq_clr();
    check("R9 clear", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule